// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and date in packed BCD. A fast oscillator strobe goes through a prescaler, and the prescaler makes one advance per second. Each advance ripples through a carry chain: seconds, then minutes, then hours, then weekday and day of month, then month, then a two-digit year. A century flag in the month register flips each time the year wraps.

Hours can be kept in a 24-hour format or in a 12-hour format with a PM flag. Month lengths follow the calendar. February has its extra day in years divisible by four.

A host port writes the registers and reads them back combinationally. Two sticky status flags record an oscillator stop and a low supply voltage, both signalled by external inputs. A write to the seconds register restarts the prescaler, so the host can align the second boundary with the moment it sets the time.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the registers read as follows: seconds 0x00, minutes 0x00, hours 0x12 (12 AM), weekday 0x00, day 0x01, month 0x01, year 0x00, control A 0x00 and control B 0x10 (stop flag set). The register addresses are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 14 control A, 15 control B.
- R2: The time advances by one second on every PRESCALE-th oscillator strobe, counted since reset or since the last seconds write.
- R3: Seconds and minutes count BCD 0x00 to 0x59. The wrap from 0x59 to 0x00 carries into the next field.
- R4: When control A bit 5 is 1, hours count BCD 0x00 to 0x23, and the wrap from 0x23 to 0x00 advances the day.
- R5: When control A bit 5 is 0, hours hold BCD 1 to 12 in bits 4:0, with bit 5 as the PM flag. The sequence is 11 AM (0x11) to 12 PM (0x32), 11 PM (0x31) to 12 AM (0x12) with a day advance, and 12 to 01 with the PM flag kept (0x12 to 0x01, 0x32 to 0x21).
- R6: The weekday counts 0 to 6 and returns to 0 on a day advance from 6.
- R7: Months 0x04, 0x06, 0x09 and 0x11 end after day 0x30. The other months except February end after day 0x31. A day advance past the last day gives day 0x01 and the next month.
- R8: February ends after day 0x29 when the BCD year is divisible by 4, and after day 0x28 otherwise.
- R9: A month advance from 0x12 gives month 0x01 and the next year. A year advance from 0x99 gives 0x00 and inverts the century flag at month register bit 7.
- R10: A seconds write clears the prescaler, so the next second advance comes PRESCALE strobes after that write.
- R11: A write loads only the implemented bits: seconds and minutes [6:0], hours [5:0], weekday [2:0], day [5:0], month [4:0] plus bit 7, year [7:0], control A bit 5. The other bits read as 0.
- R12: Control B bit 4 is set in every cycle in which the oscillator-stop input is high. It stays set until the host writes 0 to it. Writing 1 to it does not set it.
- R13: Control B bit 6 behaves in the same way for the low-voltage input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle strobe from the timebase oscillator |
| osc_stop | input | 1 | High while the oscillator is detected as stopped |
| low_volt | input | 1 | High while the supply is detected as low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 8 | Combinational read data |

## Verification
The assertions watch the carry chain on every cycle:
- a minute carry leaves the seconds at zero;
- a day carry leaves the hours at midnight in the active format;
- a month carry leaves the day at 0x01, and a year carry leaves the month at 0x01;
- the century flag changes only at a year wrap from 0x99 or through a month write;
- the prescaler counter is zero after a second advance or a seconds write;
- both status flags are set after their input is high.

Only the directed scenarios show the following: the count of strobes per second, the exact 12-hour transitions, each month length and the leap rule, the write masks, and that a flag clears only when 0 is written.

// File: rtl/cal_pkg.sv
package cal_pkg;

  // Increment a two-digit packed BCD value.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  // BCD year divisible by four.
  function automatic logic is_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  // Last BCD day of a BCD month.
  function automatic logic [5:0] last_day(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  // 24-hour successor.
  function automatic logic [5:0] hour24_next(input logic [5:0] h);
    logic [7:0] t;
    t = bcd_inc({2'b00, h});
    return (h == 6'h23) ? 6'h00 : t[5:0];
  endfunction

  // 12-hour successor: bit 5 is PM, bits 4:0 hold 1..12.
  function automatic logic [5:0] hour12_next(input logic [5:0] h);
    logic [7:0] t;
    t = bcd_inc({3'b000, h[4:0]});
    if (h[4:0] == 5'h12)      return {h[5], 5'h01};
    else if (h[4:0] == 5'h11) return {~h[5], 5'h12};
    else                      return {h[5], t[4:0]};
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic clr,
  output logic sec_tick
);
  localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;

  assign sec_tick = osc_tick && !clr && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  cnt_q <= '0;
    else if (osc_tick)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0); // R10
  AST_SECOND_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> cnt_q == '0); // R2
endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       mode24,
  input  logic       wr_sec,
  input  logic       wr_min,
  input  logic       wr_hour,
  input  logic [6:0] wr_data,
  output logic [6:0] sec_q,
  output logic [6:0] min_q,
  output logic [5:0] hour_q,
  output logic       day_carry
);
  logic       min_carry, hour_carry;
  logic [7:0] sec_inc, min_inc;

  assign sec_inc    = bcd_inc({1'b0, sec_q});
  assign min_inc    = bcd_inc({1'b0, min_q});
  assign min_carry  = adv && (sec_q == 7'h59);
  assign hour_carry = min_carry && (min_q == 7'h59);
  assign day_carry  = hour_carry && (mode24 ? (hour_q == 6'h23) : (hour_q == 6'h31));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= 7'h00;
      min_q  <= 7'h00;
      hour_q <= 6'h12;
    end else begin
      if (wr_sec)         sec_q <= wr_data;
      else if (adv)       sec_q <= (sec_q == 7'h59) ? 7'h00 : sec_inc[6:0];
      if (wr_min)         min_q <= wr_data;
      else if (min_carry) min_q <= (min_q == 7'h59) ? 7'h00 : min_inc[6:0];
      if (wr_hour)         hour_q <= wr_data[5:0];
      else if (hour_carry) hour_q <= mode24 ? hour24_next(hour_q) : hour12_next(hour_q);
    end
  end

  AST_MIN_CARRY_ZERO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    min_carry |=> sec_q == 7'h00); // R3
  AST_MIDNIGHT_24: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && mode24) |=> hour_q == 6'h00); // R4
  AST_MIDNIGHT_12: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && !mode24) |=> hour_q == 6'h12); // R5
endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic       wr_wday,
  input  logic       wr_day,
  input  logic       wr_month,
  input  logic       wr_year,
  input  logic [7:0] wr_data,
  output logic [2:0] wday_q,
  output logic [5:0] day_q,
  output logic [4:0] month_q,
  output logic       century_q,
  output logic [7:0] year_q
);
  logic       month_carry, year_carry;
  logic [7:0] day_inc, month_inc, year_inc;

  assign day_inc     = bcd_inc({2'b00, day_q});
  assign month_inc   = bcd_inc({3'b000, month_q});
  assign year_inc    = bcd_inc(year_q);
  assign month_carry = adv && (day_q == last_day(month_q, year_q));
  assign year_carry  = month_carry && (month_q == 5'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wday_q    <= 3'd0;
      day_q     <= 6'h01;
      month_q   <= 5'h01;
      century_q <= 1'b0;
      year_q    <= 8'h00;
    end else begin
      if (wr_wday)  wday_q <= wr_data[2:0];
      else if (adv) wday_q <= (wday_q == 3'd6) ? 3'd0 : wday_q + 3'd1;
      if (wr_day)   day_q <= wr_data[5:0];
      else if (adv) day_q <= month_carry ? 6'h01 : day_inc[5:0];
      if (wr_month) begin
        month_q   <= wr_data[4:0];
        century_q <= wr_data[7];
      end else if (month_carry) begin
        month_q <= (month_q == 5'h12) ? 5'h01 : month_inc[4:0];
        if (year_carry && year_q == 8'h99) century_q <= ~century_q;
      end
      if (wr_year)         year_q <= wr_data;
      else if (year_carry) year_q <= (year_q == 8'h99) ? 8'h00 : year_inc;
    end
  end

  AST_NEW_MONTH_FIRST_DAY: assert property (@(posedge clk) disable iff (!rst_n)
    month_carry |=> day_q == 6'h01); // R7
  AST_NEW_YEAR_JANUARY: assert property (@(posedge clk) disable iff (!rst_n)
    year_carry |=> month_q == 5'h01); // R9
  AST_CENTURY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((century_q != $past(century_q)) && !$past(wr_month)) |-> ($past(year_q) == 8'h99)); // R9
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core #(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       osc_stop,
  input  logic       low_volt,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam logic [3:0] A_SEC = 4'd0, A_MIN = 4'd1, A_HOUR = 4'd2, A_WDAY = 4'd3;
  localparam logic [3:0] A_DAY = 4'd4, A_MON = 4'd5, A_YEAR = 4'd6;
  localparam logic [3:0] A_CTLA = 4'd14, A_CTLB = 4'd15;

  logic       sec_tick, adv, day_carry, time_wr;
  logic       mode24_q, stop_q, vlow_q;
  logic [6:0] sec_q, min_q;
  logic [5:0] hour_q, day_q;
  logic [2:0] wday_q;
  logic [4:0] month_q;
  logic       century_q;
  logic [7:0] year_q;

  assign time_wr = wr_en && (wr_addr <= A_YEAR);
  assign adv     = sec_tick && !time_wr;

  cal_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .clr(wr_en && wr_addr == A_SEC), .sec_tick(sec_tick)
  );

  cal_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .adv(adv), .mode24(mode24_q),
    .wr_sec(wr_en && wr_addr == A_SEC), .wr_min(wr_en && wr_addr == A_MIN),
    .wr_hour(wr_en && wr_addr == A_HOUR), .wr_data(wr_data[6:0]),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .day_carry(day_carry)
  );

  cal_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .adv(day_carry),
    .wr_wday(wr_en && wr_addr == A_WDAY), .wr_day(wr_en && wr_addr == A_DAY),
    .wr_month(wr_en && wr_addr == A_MON), .wr_year(wr_en && wr_addr == A_YEAR),
    .wr_data(wr_data), .wday_q(wday_q), .day_q(day_q), .month_q(month_q),
    .century_q(century_q), .year_q(year_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode24_q <= 1'b0;
      stop_q   <= 1'b1;
      vlow_q   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTLA) mode24_q <= wr_data[5];
      stop_q <= osc_stop || (stop_q && !(wr_en && wr_addr == A_CTLB && !wr_data[4]));
      vlow_q <= low_volt || (vlow_q && !(wr_en && wr_addr == A_CTLB && !wr_data[6]));
    end
  end

  always_comb begin
    case (rd_addr)
      A_SEC:   rd_data = {1'b0, sec_q};
      A_MIN:   rd_data = {1'b0, min_q};
      A_HOUR:  rd_data = {2'b00, hour_q};
      A_WDAY:  rd_data = {5'b00000, wday_q};
      A_DAY:   rd_data = {2'b00, day_q};
      A_MON:   rd_data = {century_q, 2'b00, month_q};
      A_YEAR:  rd_data = year_q;
      A_CTLA:  rd_data = {2'b00, mode24_q, 5'b00000};
      A_CTLB:  rd_data = {1'b0, vlow_q, 1'b0, stop_q, 4'b0000};
      default: rd_data = 8'h00;
    endcase
  end

  AST_STOP_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |=> stop_q); // R12
  AST_VLOW_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    low_volt |=> vlow_q); // R13
  AST_WRITE_BLOCKS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |-> !day_carry); // R11
endmodule

// File: tb/bcd_calendar_core_tb.sv
module bcd_calendar_core_tb_top;
  localparam int P = 4;

  logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, osc_stop = 1'b0, low_volt = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_calendar_core #(.PRESCALE(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .osc_stop(osc_stop),
    .low_volt(low_volt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_err++;
      $display("FAIL %s addr %0d actual 0x%02h expected 0x%02h", req, a, rd_data, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  task automatic set_date(input logic [7:0] wd, input logic [7:0] d,
                          input logic [7:0] m, input logic [7:0] y);
    wr(4'd3, wd); wr(4'd4, d); wr(4'd5, m); wr(4'd6, y);
  endtask

  // The seconds write comes last, so the prescaler restarts from there.
  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
  endtask

  task automatic t_reset;
    chk(4'd0, 8'h00, "R1"); chk(4'd1, 8'h00, "R1"); chk(4'd2, 8'h12, "R1");
    chk(4'd3, 8'h00, "R1"); chk(4'd4, 8'h01, "R1"); chk(4'd5, 8'h01, "R1");
    chk(4'd6, 8'h00, "R1"); chk(4'd14, 8'h00, "R1"); chk(4'd15, 8'h10, "R1");
  endtask

  task automatic t_prescale;
    wr(4'd0, 8'h00);
    pulse(P - 1); chk(4'd0, 8'h00, "R2");
    pulse(1);     chk(4'd0, 8'h01, "R2");
    pulse(2); wr(4'd0, 8'h30);
    pulse(P - 1); chk(4'd0, 8'h30, "R10");
    pulse(1);     chk(4'd0, 8'h31, "R10");
  endtask

  task automatic t_minsec;
    set_time(8'h05, 8'h58, 8'h59); pulse(P);
    chk(4'd0, 8'h00, "R3"); chk(4'd1, 8'h59, "R3"); chk(4'd2, 8'h05, "R3");
    set_time(8'h05, 8'h59, 8'h59); pulse(P);
    chk(4'd1, 8'h00, "R3"); chk(4'd2, 8'h06, "R3");
  endtask

  task automatic t_hour24;
    wr(4'd14, 8'h20); chk(4'd14, 8'h20, "R4");
    set_date(8'h06, 8'h10, 8'h03, 8'h20);
    set_time(8'h23, 8'h59, 8'h59); pulse(P);
    chk(4'd2, 8'h00, "R4"); chk(4'd4, 8'h11, "R4"); chk(4'd3, 8'h00, "R6");
    set_time(8'h09, 8'h59, 8'h59); pulse(P); chk(4'd2, 8'h10, "R4");
  endtask

  task automatic t_hour12;
    wr(4'd14, 8'h00);
    set_date(8'h02, 8'h10, 8'h03, 8'h20);
    set_time(8'h11, 8'h59, 8'h59); pulse(P);
    chk(4'd2, 8'h32, "R5"); chk(4'd4, 8'h10, "R5");
    set_time(8'h31, 8'h59, 8'h59); pulse(P);
    chk(4'd2, 8'h12, "R5"); chk(4'd4, 8'h11, "R5"); chk(4'd3, 8'h03, "R6");
    set_time(8'h12, 8'h59, 8'h59); pulse(P); chk(4'd2, 8'h01, "R5");
    set_time(8'h32, 8'h59, 8'h59); pulse(P); chk(4'd2, 8'h21, "R5");
  endtask

  task automatic t_months;
    wr(4'd14, 8'h20);
    set_date(8'h01, 8'h30, 8'h04, 8'h21);
    set_time(8'h23, 8'h59, 8'h59); pulse(P);
    chk(4'd4, 8'h01, "R7"); chk(4'd5, 8'h05, "R7");
    set_date(8'h01, 8'h30, 8'h05, 8'h21);
    set_time(8'h23, 8'h59, 8'h59); pulse(P);
    chk(4'd4, 8'h31, "R7"); chk(4'd5, 8'h05, "R7");
    set_date(8'h01, 8'h30, 8'h11, 8'h21);
    set_time(8'h23, 8'h59, 8'h59); pulse(P);
    chk(4'd4, 8'h01, "R7"); chk(4'd5, 8'h12, "R7");
  endtask

  task automatic t_leap;
    set_date(8'h01, 8'h28, 8'h02, 8'h24);
    set_time(8'h23, 8'h59, 8'h59); pulse(P);
    chk(4'd4, 8'h29, "R8"); chk(4'd5, 8'h02, "R8");
    set_time(8'h23, 8'h59, 8'h59); pulse(P);
    chk(4'd4, 8'h01, "R8"); chk(4'd5, 8'h03, "R8");
    set_date(8'h01, 8'h28, 8'h02, 8'h23);
    set_time(8'h23, 8'h59, 8'h59); pulse(P);
    chk(4'd4, 8'h01, "R8"); chk(4'd5, 8'h03, "R8");
    set_date(8'h01, 8'h28, 8'h02, 8'h12);
    set_time(8'h23, 8'h59, 8'h59); pulse(P);
    chk(4'd4, 8'h29, "R8");
  endtask

  task automatic t_year;
    set_date(8'h01, 8'h31, 8'h12, 8'h41);
    set_time(8'h23, 8'h59, 8'h59); pulse(P);
    chk(4'd5, 8'h01, "R9"); chk(4'd6, 8'h42, "R9");
    set_date(8'h01, 8'h31, 8'h12, 8'h99);
    set_time(8'h23, 8'h59, 8'h59); pulse(P);
    chk(4'd5, 8'h81, "R9"); chk(4'd6, 8'h00, "R9"); chk(4'd4, 8'h01, "R9");
    set_date(8'h01, 8'h31, 8'h92, 8'h99);
    set_time(8'h23, 8'h59, 8'h59); pulse(P);
    chk(4'd5, 8'h01, "R9");
  endtask

  task automatic t_masks;
    wr(4'd3, 8'hFD); chk(4'd3, 8'h05, "R11");
    wr(4'd2, 8'hFF); chk(4'd2, 8'h3F, "R11");
    wr(4'd5, 8'hFF); chk(4'd5, 8'h9F, "R11");
    wr(4'd14, 8'hFF); chk(4'd14, 8'h20, "R11");
  endtask

  task automatic t_flags;
    wr(4'd15, 8'h00); chk(4'd15, 8'h00, "R12");
    wr(4'd15, 8'hFF); chk(4'd15, 8'h00, "R12");
    @(negedge clk) osc_stop = 1'b1;
    @(negedge clk) osc_stop = 1'b0;
    chk(4'd15, 8'h10, "R12");
    wr(4'd15, 8'hEF); chk(4'd15, 8'h00, "R12");
    @(negedge clk) low_volt = 1'b1;
    @(negedge clk) low_volt = 1'b0;
    chk(4'd15, 8'h40, "R13");
    wr(4'd15, 8'h40); chk(4'd15, 8'h40, "R13");
    wr(4'd15, 8'h00); chk(4'd15, 8'h00, "R13");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_prescale;
    t_minsec;
    t_hour24;
    t_hour12;
    t_months;
    t_leap;
    t_year;
    t_masks;
    t_flags;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run;
  end
endmodule